// File: doc/BRIEF.md
# Event-Driven Lookup-Table Logic Simulation Engine

This block simulates a mapped logic network one node at a time. Every node's logic function is held as a truth table of four-valued codes in one shared table memory. Each node also has a descriptor: where its table starts, how many fanins it has and which nodes they are, where its fanout list starts and how long it is, and whether it is a primary output. Nodes `0 .. NPI-1` are the primary inputs.

Software first loads the tables, descriptors and fanout lists through three write ports. It then presents an input vector with a one-cycle `applyVec` strobe. The engine scans the primary inputs. Each input whose code changed is recorded as an event, and its fanouts go into a pending-node FIFO. The engine then pops nodes from the FIFO one by one. For each node it reads the table entry selected by that node's current fanin codes. When the result differs from the stored value, the engine updates the value, counts an event and appends the node's fanouts. A vector is finished when the FIFO runs dry. Node values and the running event total are visible on the outputs at all times.

Top module: `lutsim_engine`

## Requirements
- R1: While `rst` is high, every node value becomes X (code 2'b10), the event counter becomes 0, and `busy`, `done` and `overflow` go low.
- R2: Signal codes are 00 = 0, 01 = 1, 10 = X and 11 = Z. For a node with n fanins, the table word that is read sits at the node base plus an index. That index is formed from the fanin codes: fanin i occupies bits [2i+1:2i], and the bits above 2n are zero.
- R3: The engine takes `vecIn[2p+1:2p]` as the code for primary input p. Inputs are scanned in ascending order. Each input whose code differs from its stored value is updated and counts one event, and its fanout list is appended to the FIFO in list order.
- R4: Nodes are evaluated in FIFO order. A node whose table result differs from its stored value is updated, counts one event, and has its fanout list appended to the FIFO tail.
- R5: A node whose table result equals its stored value keeps its value, counts no event and appends nothing. A vector identical to the previous one produces no events.
- R6: A node whose primary-output flag is set never appends fanouts, even when its value changes and its fanout list is not empty.
- R7: `busy` is high from the cycle after an accepted `applyVec` until the FIFO is empty. `done` pulses for exactly one cycle, in the cycle `busy` falls.
- R8: A node that is queued several times for one vector is evaluated once for each entry.
- R9: If a fanout append finds the FIFO full, `overflow` goes high and the engine stops (`busy` low, `done` pulse). The flag stays high until the next accepted vector, which clears it and flushes the FIFO.
- R10: An `applyVec` strobe that arrives while `busy` is high is ignored.
- R11: `eventCount` is the running total of all input and node events since reset. It grows by one per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tblWe | input | 1 | Write strobe for the table memory |
| tblAddr | input | TBL_AW | Table word address |
| tblVal | input | 2 | Table word (four-valued code) |
| descWe | input | 1 | Write strobe for a node descriptor |
| descIdx | input | log2(NODES) | Node being described |
| descBase | input | TBL_AW | Start of the node's table |
| descFanN | input | log2(MAX_FANIN+1) | Number of fanins |
| descFanins | input | MAX_FANIN*log2(NODES) | Fanin node indices, fanin 0 in the low field |
| descFoPtr | input | FO_AW | Start of the node's fanout list |
| descFoCnt | input | FO_AW+1 | Length of the fanout list |
| descIsPo | input | 1 | Primary-output flag |
| foWe | input | 1 | Write strobe for the fanout list memory |
| foAddr | input | FO_AW | Fanout list word address |
| foNode | input | log2(NODES) | Node index stored in the list |
| applyVec | input | 1 | Start simulating `vecIn` |
| vecIn | input | 2*NPI | Primary input codes |
| busy | output | 1 | Engine is working on a vector |
| done | output | 1 | One-cycle pulse when a vector finishes |
| overflow | output | 1 | FIFO overflow halted the last vector |
| eventCount | output | CNT_W | Running event total |
| nodeVals | output | 2*NODES | Current code of every node, node i at bits [2i+1:2i] |

## Verification
Two functions can meet in one cycle. The first is a new `applyVec` arriving while an earlier vector is still being scanned. The bench provokes this by strobing a second, different vector one cycle after the first. It judges the outcome by checking that node values, event total and the number of `done` pulses match a run of the first vector alone. The second is a fanout append that meets a full FIFO. The bench forces this by temporarily loading a primary input with a nine-entry fanout list against an eight-deep FIFO. Against a built-in model of the queue, it checks that the flag rises, that no queued node is evaluated, and that the next vector clears the flag. An exhaustive sweep of all 256 input vectors checks every node value and the event total, vector by vector, against the same model.

// File: rtl/lutsim_pkg.sv
package lutsim_pkg;
  localparam logic [1:0] SIG_LO  = 2'b00;
  localparam logic [1:0] SIG_HI  = 2'b01;
  localparam logic [1:0] SIG_UNK = 2'b10;
  localparam logic [1:0] SIG_HIZ = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_WALK,
    ST_POP,
    ST_EVAL
  } eng_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startVec;  // capture vector, flush queue, clear overflow
    logic nextPi;    // advance scan index
    logic loadHead;  // pop queue head into current node
    logic commit;    // write new value, count event, arm fanout walk
    logic usePi;     // commit source is the vector, not the table
    logic pushFo;    // append next fanout to the queue
    logic flagOvf;   // queue full on append
  } eng_strobe_t;
endpackage

// File: rtl/lutsim_fifo.sv
module lutsim_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] fill;

  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));
  assign dout  = store[rdPtr];

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (push && !pop)      fill <= fill + 1'b1;
      else if (pop && !push) fill <= fill - 1'b1;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/lutsim_dp.sv
module lutsim_dp
  import lutsim_pkg::*;
#(
  parameter int NODES     = 16,
  parameter int NPI       = 4,
  parameter int MAX_FANIN = 3,
  parameter int TBL_AW    = 9,
  parameter int FO_AW     = 6,
  parameter int Q_DEPTH   = 8,
  parameter int CNT_W     = 16,
  localparam int NW       = $clog2(NODES),
  localparam int FCW      = $clog2(MAX_FANIN + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tblWe,
  input  logic [TBL_AW-1:0]       tblAddr,
  input  logic [1:0]              tblVal,
  input  logic                    descWe,
  input  logic [NW-1:0]           descIdx,
  input  logic [TBL_AW-1:0]       descBase,
  input  logic [FCW-1:0]          descFanN,
  input  logic [MAX_FANIN*NW-1:0] descFanins,
  input  logic [FO_AW-1:0]        descFoPtr,
  input  logic [FO_AW:0]          descFoCnt,
  input  logic                    descIsPo,
  input  logic                    foWe,
  input  logic [FO_AW-1:0]        foAddr,
  input  logic [NW-1:0]           foNode,
  input  logic [2*NPI-1:0]        vecIn,
  input  eng_strobe_t             st,
  output logic                    piDiff,
  output logic                    evalDiff,
  output logic                    piLast,
  output logic                    walkDone,
  output logic                    qEmpty,
  output logic                    qFull,
  output logic                    overflow,
  output logic [CNT_W-1:0]        eventCount,
  output logic [2*NODES-1:0]      nodeVals
);
  localparam int TBL_N = 1 << TBL_AW;
  localparam int FO_N  = 1 << FO_AW;

  // storage loaded by software
  logic [1:0]        tblMem [TBL_N];
  logic [NW-1:0]     foMem  [FO_N];
  logic [TBL_AW-1:0] dBase  [NODES];
  logic [FCW-1:0]    dFanN  [NODES];
  logic [NW-1:0]     dFan   [NODES][MAX_FANIN];
  logic [FO_AW-1:0]  dFoPtr [NODES];
  logic [FO_AW:0]    dFoCnt [NODES];
  logic              dIsPo  [NODES];

  // simulation state
  logic [1:0]        val [NODES];
  logic [2*NPI-1:0]  vecReg;
  logic [NW-1:0]     curNode;
  logic [FO_AW-1:0]  walkPtr;
  logic [FO_AW:0]    walkCnt;
  logic [NW-1:0]     qHead;
  logic [TBL_AW-1:0] tIdx;
  logic [TBL_AW-1:0] tAddr;
  logic [1:0]        tblOut;
  logic [1:0]        piCode;

  always_ff @(posedge clk) begin
    if (tblWe) tblMem[tblAddr] <= tblVal;
    if (foWe)  foMem[foAddr]   <= foNode;
    if (descWe) begin
      dBase[descIdx]  <= descBase;
      dFanN[descIdx]  <= descFanN;
      dFoPtr[descIdx] <= descFoPtr;
      dFoCnt[descIdx] <= descFoCnt;
      dIsPo[descIdx]  <= descIsPo;
      for (int i = 0; i < MAX_FANIN; i++)
        dFan[descIdx][i] <= descFanins[i*NW +: NW];
    end
  end

  // table index: fanin i code in bits [2i+1:2i]
  always_comb begin
    tIdx = '0;
    for (int i = 0; i < MAX_FANIN; i++) begin
      if (FCW'(i) < dFanN[curNode]) tIdx[2*i +: 2] = val[dFan[curNode][i]];
    end
    tAddr  = dBase[curNode] + tIdx;
    tblOut = tblMem[tAddr];
  end

  assign piCode   = vecReg[2*curNode +: 2];
  assign piDiff   = (piCode != val[curNode]);
  assign evalDiff = (tblOut != val[curNode]);
  assign piLast   = (curNode == NW'(NPI - 1));
  assign walkDone = (walkCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NODES; i++) val[i] <= SIG_UNK;
      vecReg     <= '0;
      curNode    <= '0;
      walkPtr    <= '0;
      walkCnt    <= '0;
      overflow   <= 1'b0;
      eventCount <= '0;
    end else begin
      if (st.startVec) begin
        vecReg   <= vecIn;
        curNode  <= '0;
        overflow <= 1'b0;
      end
      if (st.nextPi)   curNode <= curNode + 1'b1;
      if (st.loadHead) curNode <= qHead;
      if (st.commit) begin
        val[curNode] <= st.usePi ? piCode : tblOut;
        eventCount   <= eventCount + 1'b1;
        walkPtr      <= dFoPtr[curNode];
        walkCnt      <= dIsPo[curNode] ? '0 : dFoCnt[curNode];
      end
      if (st.pushFo) begin
        walkPtr <= walkPtr + 1'b1;
        walkCnt <= walkCnt - 1'b1;
      end
      if (st.flagOvf) overflow <= 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NODES; i++) nodeVals[2*i +: 2] = val[i];
  end

  lutsim_fifo #(.DEPTH(Q_DEPTH), .DW(NW)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .clr   (st.startVec),
    .push  (st.pushFo),
    .din   (foMem[walkPtr]),
    .pop   (st.loadHead),
    .dout  (qHead),
    .empty (qEmpty),
    .full  (qFull)
  );

  // R11
  evt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (eventCount != $past(eventCount)) |-> (eventCount == $past(eventCount) + 1'b1));
  // R6
  po_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st.commit && !st.usePi && dIsPo[curNode]) |=> walkDone);
  // R9
  ovf_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !st.startVec) |-> !st.pushFo);
endmodule

// File: rtl/lutsim_ctrl.sv
module lutsim_ctrl
  import lutsim_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        applyVec,
  input  logic        piDiff,
  input  logic        evalDiff,
  input  logic        piLast,
  input  logic        walkDone,
  input  logic        qEmpty,
  input  logic        qFull,
  output eng_strobe_t st,
  output logic        busy,
  output logic        done
);
  eng_state_t state, nxt;
  logic       fromScan;

  always_comb begin
    st  = '0;
    nxt = state;
    case (state)
      ST_IDLE: if (applyVec) begin
        st.startVec = 1'b1;
        nxt = ST_SCAN;
      end
      ST_SCAN: begin
        if (piDiff) begin
          st.commit = 1'b1;
          st.usePi  = 1'b1;
          nxt = ST_WALK;
        end else if (piLast) begin
          nxt = ST_POP;
        end else begin
          st.nextPi = 1'b1;
        end
      end
      ST_WALK: begin
        if (walkDone) begin
          if (!fromScan || piLast) nxt = ST_POP;
          else begin
            st.nextPi = 1'b1;
            nxt = ST_SCAN;
          end
        end else if (qFull) begin
          st.flagOvf = 1'b1;
          nxt = ST_IDLE;
        end else begin
          st.pushFo = 1'b1;
        end
      end
      ST_POP: begin
        if (qEmpty) nxt = ST_IDLE;
        else begin
          st.loadHead = 1'b1;
          nxt = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (evalDiff) begin
          st.commit = 1'b1;
          nxt = ST_WALK;
        end else begin
          nxt = ST_POP;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      fromScan <= 1'b0;
      done     <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state != ST_IDLE) && (nxt == ST_IDLE);
      if (state == ST_SCAN)      fromScan <= 1'b1;
      else if (state == ST_EVAL) fromScan <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && applyVec) |-> !st.startVec);
endmodule

// File: rtl/lutsim_engine.sv
module lutsim_engine
  import lutsim_pkg::*;
#(
  parameter int NODES     = 16,
  parameter int NPI       = 4,
  parameter int MAX_FANIN = 3,
  parameter int TBL_AW    = 9,
  parameter int FO_AW     = 6,
  parameter int Q_DEPTH   = 8,
  parameter int CNT_W     = 16,
  localparam int NW       = $clog2(NODES),
  localparam int FCW      = $clog2(MAX_FANIN + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tblWe,
  input  logic [TBL_AW-1:0]       tblAddr,
  input  logic [1:0]              tblVal,
  input  logic                    descWe,
  input  logic [NW-1:0]           descIdx,
  input  logic [TBL_AW-1:0]       descBase,
  input  logic [FCW-1:0]          descFanN,
  input  logic [MAX_FANIN*NW-1:0] descFanins,
  input  logic [FO_AW-1:0]        descFoPtr,
  input  logic [FO_AW:0]          descFoCnt,
  input  logic                    descIsPo,
  input  logic                    foWe,
  input  logic [FO_AW-1:0]        foAddr,
  input  logic [NW-1:0]           foNode,
  input  logic                    applyVec,
  input  logic [2*NPI-1:0]        vecIn,
  output logic                    busy,
  output logic                    done,
  output logic                    overflow,
  output logic [CNT_W-1:0]        eventCount,
  output logic [2*NODES-1:0]      nodeVals
);
  eng_strobe_t st;
  logic piDiff, evalDiff, piLast, walkDone, qEmpty, qFull;

  lutsim_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .applyVec (applyVec),
    .piDiff   (piDiff),
    .evalDiff (evalDiff),
    .piLast   (piLast),
    .walkDone (walkDone),
    .qEmpty   (qEmpty),
    .qFull    (qFull),
    .st       (st),
    .busy     (busy),
    .done     (done)
  );

  lutsim_dp #(
    .NODES(NODES), .NPI(NPI), .MAX_FANIN(MAX_FANIN), .TBL_AW(TBL_AW),
    .FO_AW(FO_AW), .Q_DEPTH(Q_DEPTH), .CNT_W(CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .tblWe      (tblWe),
    .tblAddr    (tblAddr),
    .tblVal     (tblVal),
    .descWe     (descWe),
    .descIdx    (descIdx),
    .descBase   (descBase),
    .descFanN   (descFanN),
    .descFanins (descFanins),
    .descFoPtr  (descFoPtr),
    .descFoCnt  (descFoCnt),
    .descIsPo   (descIsPo),
    .foWe       (foWe),
    .foAddr     (foAddr),
    .foNode     (foNode),
    .vecIn      (vecIn),
    .st         (st),
    .piDiff     (piDiff),
    .evalDiff   (evalDiff),
    .piLast     (piLast),
    .walkDone   (walkDone),
    .qEmpty     (qEmpty),
    .qFull      (qFull),
    .overflow   (overflow),
    .eventCount (eventCount),
    .nodeVals   (nodeVals)
  );
endmodule

// File: tb/lutsim_engine_tb.sv
module lutsim_engine_tb;
  localparam int NODES = 16, NPI = 4, MF = 3, TBL_AW = 9, FO_AW = 6, QD = 8, CNT_W = 16;
  localparam int NW = 4;

  logic clk = 0, rst = 1;
  logic tblWe = 0; logic [TBL_AW-1:0] tblAddr = '0; logic [1:0] tblVal = '0;
  logic descWe = 0; logic [NW-1:0] descIdx = '0; logic [TBL_AW-1:0] descBase = '0;
  logic [1:0] descFanN = '0; logic [MF*NW-1:0] descFanins = '0;
  logic [FO_AW-1:0] descFoPtr = '0; logic [FO_AW:0] descFoCnt = '0; logic descIsPo = 0;
  logic foWe = 0; logic [FO_AW-1:0] foAddr = '0; logic [NW-1:0] foNode = '0;
  logic applyVec = 0; logic [2*NPI-1:0] vecIn = '0;
  logic busy, done, overflow;
  logic [CNT_W-1:0] eventCount;
  logic [2*NODES-1:0] nodeVals;

  always #2 clk = ~clk;

  lutsim_engine u_dut (
    .clk(clk), .rst(rst), .tblWe(tblWe), .tblAddr(tblAddr), .tblVal(tblVal),
    .descWe(descWe), .descIdx(descIdx), .descBase(descBase), .descFanN(descFanN),
    .descFanins(descFanins), .descFoPtr(descFoPtr), .descFoCnt(descFoCnt),
    .descIsPo(descIsPo), .foWe(foWe), .foAddr(foAddr), .foNode(foNode),
    .applyVec(applyVec), .vecIn(vecIn), .busy(busy), .done(done),
    .overflow(overflow), .eventCount(eventCount), .nodeVals(nodeVals)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  // reference model state
  int mOp[NODES], mN[NODES], mF[NODES][MF], mPtr[NODES], mCnt[NODES];
  bit mPo[NODES];
  int mFo[64];
  logic [1:0] mv[NODES];
  int mEvents = 0;
  bit mOvf = 0;
  int mq[QD]; int qh, qn;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // four-valued AND(0)/OR(1)/XOR(2); X and Z both unknown
  function automatic logic [1:0] f4(input int op, input int n, input logic [1:0] a, b, c);
    logic [1:0] cs[3];
    int ones, zeros, unk;
    cs = '{a, b, c}; ones = 0; zeros = 0; unk = 0;
    for (int i = 0; i < n; i++) begin
      if (cs[i] == 2'b00) zeros++;
      else if (cs[i] == 2'b01) ones++;
      else unk++;
    end
    if (op == 0) return (zeros > 0) ? 2'b00 : (unk > 0) ? 2'b10 : 2'b01;
    if (op == 1) return (ones > 0) ? 2'b01 : (unk > 0) ? 2'b10 : 2'b00;
    return (unk > 0) ? 2'b10 : 2'(ones % 2);
  endfunction

  task automatic setDesc(input int idx, input int op, input int n, input int a, input int b,
                         input int c, input int base, input int ptr, input int cnt, input bit po);
    mOp[idx] = op; mN[idx] = n; mF[idx][0] = a; mF[idx][1] = b; mF[idx][2] = c;
    mPtr[idx] = ptr; mCnt[idx] = cnt; mPo[idx] = po;
    @(negedge clk);
    descWe = 1; descIdx = NW'(idx); descBase = TBL_AW'(base); descFanN = 2'(n);
    descFanins = {NW'(c), NW'(b), NW'(a)}; descFoPtr = FO_AW'(ptr);
    descFoCnt = (FO_AW+1)'(cnt); descIsPo = po;
    @(negedge clk); descWe = 0;
    // R2: table word at base + codes with fanin i in bits [2i+1:2i]
    if (n > 0) for (int k = 0; k < (1 << (2*n)); k++) begin
      tblWe = 1; tblAddr = TBL_AW'(base + k);
      tblVal = f4(op, n, 2'(k), 2'(k >> 2), 2'(k >> 4));
      @(negedge clk);
    end
    tblWe = 0;
  endtask

  task automatic setFo(input int addr, input int node);
    mFo[addr] = node;
    @(negedge clk);
    foWe = 1; foAddr = FO_AW'(addr); foNode = NW'(node);
    @(negedge clk); foWe = 0;
  endtask

  task automatic mPush(input int node);
    if (qn == QD) mOvf = 1;
    else begin mq[(qh + qn) % QD] = node; qn++; end
  endtask

  task automatic mFanout(input int node);
    if (!mPo[node])
      for (int j = 0; j < mCnt[node] && !mOvf; j++) mPush(mFo[mPtr[node] + j]);
  endtask

  task automatic modelRun(input logic [2*NPI-1:0] v);
    int n; logic [1:0] nv;
    qh = 0; qn = 0; mOvf = 0;
    for (int p = 0; p < NPI && !mOvf; p++) begin
      if (v[2*p +: 2] != mv[p]) begin
        mv[p] = v[2*p +: 2]; mEvents++; mFanout(p);
      end
    end
    while (qn > 0 && !mOvf) begin
      n = mq[qh]; qh = (qh + 1) % QD; qn--;
      nv = f4(mOp[n], mN[n], mv[mF[n][0]], mv[mF[n][1]], mv[mF[n][2]]);
      if (nv != mv[n]) begin mv[n] = nv; mEvents++; mFanout(n); end
    end
  endtask

  function automatic logic [2*NODES-1:0] mVals();
    logic [2*NODES-1:0] r;
    for (int i = 0; i < NODES; i++) r[2*i +: 2] = mv[i];
    return r;
  endfunction

  // apply a vector, optionally poke a second one while busy, wait for completion
  task automatic runVec(input logic [2*NPI-1:0] v, input bit poke, input logic [2*NPI-1:0] v2);
    int dones;
    dones = 0;
    @(negedge clk); applyVec = 1; vecIn = v;
    @(negedge clk); applyVec = 0;
    if (poke) begin
      applyVec = 1; vecIn = v2;
      @(negedge clk); applyVec = 0;
      if (done) dones++;
    end
    while (busy) begin
      @(negedge clk);
      if (done) dones++;
    end
    modelRun(v);
    chk("R4/R6/R8 node values", 64'(nodeVals), 64'(mVals()));
    chk("R3/R5/R11 event total", 64'(eventCount), 64'(mEvents));
    chk("R7 single done pulse", 64'(dones), 64'd1);
    chk("R9 overflow flag", 64'(overflow), 64'(mOvf));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NODES; i++) mv[i] = 2'b10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state (sampled while reset is asserted)
    chk("R1 values X", 64'(nodeVals), 64'(mVals()));
    chk("R1 events zero", 64'(eventCount), 64'd0);
    chk("R1 idle flags", 64'({busy, done, overflow}), 64'd0);
    rst = 0;

    // primary inputs 0..3 with fanout lists
    setDesc(0, 0, 0, 0, 0, 0, 0, 0, 2, 0);
    setDesc(1, 0, 0, 0, 0, 0, 0, 2, 2, 0);
    setDesc(2, 0, 0, 0, 0, 0, 0, 4, 1, 0);
    setDesc(3, 0, 0, 0, 0, 0, 0, 5, 1, 0);
    setDesc(4, 0, 2, 0, 1, 0, 0,   6, 1, 0); // AND(p0,p1)
    setDesc(5, 1, 2, 1, 2, 0, 16,  7, 1, 0); // OR(p1,p2)
    setDesc(6, 2, 2, 4, 3, 0, 32,  8, 2, 0); // XOR(n4,p3)
    setDesc(7, 2, 3, 5, 6, 0, 48, 10, 1, 1); // XOR(n5,n6,p0), output flag set (R6)
    setDesc(8, 1, 2, 6, 7, 0, 112, 0, 0, 1); // OR(n6,n7), output
    for (int i = 9; i < NODES; i++) setDesc(i, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    setFo(0, 4); setFo(1, 7); setFo(2, 4); setFo(3, 5); setFo(4, 5); setFo(5, 6);
    setFo(6, 6); setFo(7, 7); setFo(8, 7); setFo(9, 8); setFo(10, 8);
    for (int i = 40; i < 49; i++) setFo(i, 5);

    // exhaustive sweep over all four-valued input vectors
    for (int v = 0; v < 256; v++) runVec(8'(v), 0, '0);

    // R5: same vector again, no events
    runVec(8'hFF, 0, '0);
    runVec(8'b01_00_01_01, 0, '0);
    chk("R2 three-fanin node", 64'(nodeVals[15:14]),
        64'(f4(2, 3, mv[5], mv[6], mv[0])));
    chk("R2 AND node", 64'(nodeVals[9:8]), 64'(2'b01));

    // R10: second strobe while busy is ignored
    runVec(8'b00_01_00_00, 1, 8'b11_10_11_10);

    // R9: nine appends into eight-deep queue from input 2
    setDesc(2, 0, 0, 0, 0, 0, 0, 40, 9, 0);
    runVec(8'b00_00_00_00, 0, '0);
    chk("R9 overflow raised", 64'(overflow), 64'd1);
    setDesc(2, 0, 0, 0, 0, 0, 0, 4, 1, 0);
    runVec(8'b01_01_01_00, 0, '0);
    chk("R9 overflow cleared", 64'(overflow), 64'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule